// File: doc/BRIEF.md
# Nested Reset Sequencer with Per-Core Reset Cause

The block turns raw reset requests into three nested reset outputs: one for the always-on RTC domain, one for the whole digital core, and one per CPU core. A wide reset always implies every narrower one. Each request is taken in asynchronously and released through a two-flop synchronizer. A per-domain state machine then holds its output for a fixed quiet period after the last request that feeds it goes away. No output of the block clears or initialises memory.

The block has three request levels. The system level covers power-on, brown-out and the RTC watchdog, and resets every domain. The core level covers the software system reset, the main watchdog and deep-sleep wake, and leaves the RTC domain running. The CPU level is one request per core and resets only that core's CPU registers.

Each core keeps its own 8-bit cause register. These registers sit in the RTC domain, so core and CPU resets do not clear them. Power-on loads both with 0x01. A read port selects one core's cause register.

Each domain runs a state machine with three states. `RS_IDLE` means no reset is active. `RS_HOLD` means the synchronized request is present. `RS_STRETCH` means the request has gone and the quiet period is being counted. The transitions are as follows:
- power-on forces `RS_HOLD`;
- `RS_IDLE` goes to `RS_HOLD` when a request appears;
- `RS_HOLD` goes to `RS_STRETCH` when the request is seen low;
- `RS_STRETCH` goes back to `RS_HOLD` if a request returns;
- `RS_STRETCH` goes to `RS_IDLE` once the hold count has run out.

Top module: `rstc_top`

## Requirements
- R1: A reset output rises as soon as a request of its level or of a wider level rises, without waiting for a clock edge.
- R2: After a raw request drops, between clock edges, the output of that request's own level stays high at the following 18 falling-edge samples and is low at the 19th. This gives 16 cycles of quiet after the synchronizer releases.
- R3: Resets are nested. The digital-core reset is released 17 samples after the RTC reset, and each CPU reset 17 samples after the digital-core reset. A system request therefore gives 18, 35 and 52 high samples.
- R4: Core-level requests (software, main watchdog, deep sleep) never raise the RTC reset. They give 18 high samples on the digital-core reset and 35 on each CPU reset.
- R5: System-level causes are 0x01 for power-on, 0x0F for brown-out and 0x10 for the RTC watchdog. Each is written into both cores' cause registers. While power-on is held, every output is high and both cause registers read 0x01.
- R6: Core-level causes are 0x03 for software, 0x07 for the main watchdog and 0x05 for deep sleep. Each is written into both cores' cause registers.
- R7: A CPU request for core k raises only that core's CPU reset, with 18 high samples. It writes 0x0C into core k's cause register only, and the other core's register keeps its value.
- R8: When requests are active together, the widest level wins. Within a level the order is power-on, brown-out, RTC watchdog at system level, and software, main watchdog, deep sleep at core level. Only the winning code is written.
- R9: A cause register keeps its code after the reset that logged it has been released and while narrower resets run. `cause_o` returns the register of the core numbered by `cause_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_req_i | input | 1 | Power-on request, active high, asynchronous |
| bod_req_i | input | 1 | Brown-out request |
| rwdt_req_i | input | 1 | RTC watchdog request |
| swsys_req_i | input | 1 | Software system reset request |
| mwdt_req_i | input | 1 | Main watchdog request |
| sleep_req_i | input | 1 | Deep-sleep wake request |
| cpu_req_i | input | NCORE | Per-core CPU reset request |
| cause_sel_i | input | SELW | Core whose cause is read |
| rtc_rst_o | output | 1 | RTC domain reset, active high |
| dig_rst_o | output | 1 | Digital core reset, active high |
| cpu_rst_o | output | NCORE | Per-core CPU reset, active high |
| cause_o | output | 8 | Selected core's cause code |

## Verification
Each request is applied on its own, which ties every source to its code and to the set of outputs it moves. The three release lengths (18, 35 and 52 samples) separate system-level, core-level and CPU-level handling. Combined requests check the priority order: three core-level sources together, two system-level sources, and a system request mixed with core and CPU requests. Alternating core and per-core CPU requests tell a per-core write apart from a shared one, and show whether an untouched register keeps its earlier code.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    localparam int CODE_W = 8;
    typedef logic [CODE_W-1:0] cause_t;

    localparam cause_t CODE_POR   = 8'h01;
    localparam cause_t CODE_BOD   = 8'h0F;
    localparam cause_t CODE_RWDT  = 8'h10;
    localparam cause_t CODE_SWSYS = 8'h03;
    localparam cause_t CODE_SLEEP = 8'h05;
    localparam cause_t CODE_MWDT  = 8'h07;
    localparam cause_t CODE_CPU   = 8'h0C;

    typedef enum logic [1:0] {
        RS_IDLE    = 2'd0,
        RS_HOLD    = 2'd1,
        RS_STRETCH = 2'd2
    } rs_state_e;

    localparam int NWIDE = 6;
    localparam int IDX_POR   = 0;
    localparam int IDX_BOD   = 1;
    localparam int IDX_RWDT  = 2;
    localparam int IDX_SWSYS = 3;
    localparam int IDX_MWDT  = 4;
    localparam int IDX_SLEEP = 5;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic req_i,
    output logic lvl_o
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk or posedge req_i) begin
        if (req_i) q <= '1;
        else       q <= {q[STAGES-2:0], 1'b0};
    end

    assign lvl_o = q[STAGES-1];
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch
    import rstc_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic arst_i,
    input  logic lvl_i,
    output logic rst_o
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    rs_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or posedge arst_i) begin
        if (arst_i) begin
            state_q <= RS_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RS_IDLE: begin
                if (lvl_i) state_d = RS_HOLD;
            end
            RS_HOLD: begin
                if (!lvl_i) begin
                    state_d = RS_STRETCH;
                    cnt_d   = '0;
                end
            end
            RS_STRETCH: begin
                if (lvl_i)             state_d = RS_HOLD;
                else if (cnt_q == LAST) state_d = RS_IDLE;
                else                   cnt_d   = cnt_q + 1'b1;
            end
            default: state_d = RS_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        rst_o = lvl_i | (state_q != RS_IDLE);
    end

    // checker: cycles since the input last went quiet
    logic [CW:0] quiet_q;
    always_ff @(posedge clk or posedge arst_i) begin
        if (arst_i)                         quiet_q <= '0;
        else if (lvl_i)                     quiet_q <= '0;
        else if (quiet_q != (CW+1)'(HOLD_CYC)) quiet_q <= quiet_q + 1'b1;
    end

    assert_hold_min_R2: assert property (@(posedge clk) disable iff (arst_i)
        $fell(rst_o) |-> (quiet_q >= (CW+1)'(HOLD_CYC)));

    assert_release_quiet_R2: assert property (@(posedge clk) disable iff (arst_i)
        $fell(rst_o) |-> (!lvl_i && $past(!lvl_i)));
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
    import rstc_pkg::*;
#(
    parameter int NCORE = 2,
    parameter int SELW  = 1
) (
    input  logic             clk,
    input  logic             arst_i,
    input  logic             bod_i,
    input  logic             rwdt_i,
    input  logic             swsys_i,
    input  logic             mwdt_i,
    input  logic             sleep_i,
    input  logic [NCORE-1:0] cpu_i,
    input  logic [SELW-1:0]  sel_i,
    output cause_t           cause_o
);
    cause_t cause_q [NCORE];
    logic   wide_any;

    assign wide_any = bod_i | rwdt_i | swsys_i | mwdt_i | sleep_i;

    for (genvar i = 0; i < NCORE; i++) begin : g_core
        cause_t win;
        logic   hit;

        always_comb begin
            hit = 1'b1;
            win = CODE_POR;
            if      (bod_i)    win = CODE_BOD;
            else if (rwdt_i)   win = CODE_RWDT;
            else if (swsys_i)  win = CODE_SWSYS;
            else if (mwdt_i)   win = CODE_MWDT;
            else if (sleep_i)  win = CODE_SLEEP;
            else if (cpu_i[i]) win = CODE_CPU;
            else               hit = 1'b0;
        end

        always_ff @(posedge clk or posedge arst_i) begin
            if (arst_i)   cause_q[i] <= CODE_POR;
            else if (hit) cause_q[i] <= win;
        end

        assert_cpu_code_R7: assert property (@(posedge clk) disable iff (arst_i)
            (cpu_i[i] && !wide_any) |=> (cause_q[i] == CODE_CPU));

        assert_untouched_kept_R7: assert property (@(posedge clk) disable iff (arst_i)
            (!wide_any && !cpu_i[i]) |=> $stable(cause_q[i]));

        assert_bod_wins_R8: assert property (@(posedge clk) disable iff (arst_i)
            bod_i |=> (cause_q[i] == CODE_BOD));

        assert_sw_over_core_R8: assert property (@(posedge clk) disable iff (arst_i)
            (swsys_i && !bod_i && !rwdt_i) |=> (cause_q[i] == CODE_SWSYS));
    end

    always_comb begin
        cause_o = '0;
        for (int k = 0; k < NCORE; k++)
            if (sel_i == SELW'(k)) cause_o = cause_q[k];
    end
endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int NCORE       = 2,
    parameter int HOLD_CYC    = 16,
    parameter int SYNC_STAGES = 2,
    localparam int SELW       = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic             clk,
    input  logic             por_req_i,
    input  logic             bod_req_i,
    input  logic             rwdt_req_i,
    input  logic             swsys_req_i,
    input  logic             mwdt_req_i,
    input  logic             sleep_req_i,
    input  logic [NCORE-1:0] cpu_req_i,
    input  logic [SELW-1:0]  cause_sel_i,
    output logic             rtc_rst_o,
    output logic             dig_rst_o,
    output logic [NCORE-1:0] cpu_rst_o,
    output logic [7:0]       cause_o
);
    logic [NWIDE-1:0] wide_raw, wide_lvl;
    logic [NCORE-1:0] cpu_lvl;
    logic             rtc_lvl, dig_lvl;

    assign wide_raw[IDX_POR]   = por_req_i;
    assign wide_raw[IDX_BOD]   = bod_req_i;
    assign wide_raw[IDX_RWDT]  = rwdt_req_i;
    assign wide_raw[IDX_SWSYS] = swsys_req_i;
    assign wide_raw[IDX_MWDT]  = mwdt_req_i;
    assign wide_raw[IDX_SLEEP] = sleep_req_i;

    for (genvar w = 0; w < NWIDE; w++) begin : g_wsync
        rstc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .req_i(wide_raw[w]), .lvl_o(wide_lvl[w]));
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_csync
        rstc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .req_i(cpu_req_i[c]), .lvl_o(cpu_lvl[c]));
    end

    logic por_lvl;
    assign por_lvl = wide_lvl[IDX_POR];

    assign rtc_lvl = wide_lvl[IDX_POR] | wide_lvl[IDX_BOD] | wide_lvl[IDX_RWDT];
    assign dig_lvl = rtc_rst_o | wide_lvl[IDX_SWSYS] | wide_lvl[IDX_MWDT]
                   | wide_lvl[IDX_SLEEP];

    rstc_stretch #(.HOLD_CYC(HOLD_CYC)) u_rtc (
        .clk(clk), .arst_i(por_lvl), .lvl_i(rtc_lvl), .rst_o(rtc_rst_o));

    rstc_stretch #(.HOLD_CYC(HOLD_CYC)) u_dig (
        .clk(clk), .arst_i(por_lvl), .lvl_i(dig_lvl), .rst_o(dig_rst_o));

    for (genvar c = 0; c < NCORE; c++) begin : g_cpu
        logic cl;
        assign cl = dig_rst_o | cpu_lvl[c];
        rstc_stretch #(.HOLD_CYC(HOLD_CYC)) u_cpu (
            .clk(clk), .arst_i(por_lvl), .lvl_i(cl), .rst_o(cpu_rst_o[c]));

        assert_cpu_after_dig_R3: assert property (@(posedge clk) disable iff (por_lvl)
            $fell(cpu_rst_o[c]) |-> $past(!dig_rst_o));
    end

    rstc_cause #(.NCORE(NCORE), .SELW(SELW)) u_cause (
        .clk(clk), .arst_i(por_lvl),
        .bod_i(wide_lvl[IDX_BOD]), .rwdt_i(wide_lvl[IDX_RWDT]),
        .swsys_i(wide_lvl[IDX_SWSYS]), .mwdt_i(wide_lvl[IDX_MWDT]),
        .sleep_i(wide_lvl[IDX_SLEEP]), .cpu_i(cpu_lvl),
        .sel_i(cause_sel_i), .cause_o(cause_o));

    assert_dig_after_rtc_R3: assert property (@(posedge clk) disable iff (por_lvl)
        $fell(dig_rst_o) |-> $past(!rtc_rst_o));

    assert_code_legal_R9: assert property (@(posedge clk) disable iff (por_lvl)
        (cause_o == CODE_POR) || (cause_o == CODE_BOD) || (cause_o == CODE_RWDT) ||
        (cause_o == CODE_SWSYS) || (cause_o == CODE_MWDT) ||
        (cause_o == CODE_SLEEP) || (cause_o == CODE_CPU));
endmodule

// File: tb/tb_rstc_top.sv
module tb_rstc_top;
    localparam int NCORE = 2;

    logic clk = 1'b0;
    logic por_req = 1'b0, bod_req = 1'b0, rwdt_req = 1'b0;
    logic sw_req = 1'b0, mwdt_req = 1'b0, sleep_req = 1'b0;
    logic [NCORE-1:0] cpu_req = '0;
    logic [0:0] sel = '0;
    logic rtc_rst, dig_rst;
    logic [NCORE-1:0] cpu_rst;
    logic [7:0] cause;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    rstc_top #(.NCORE(NCORE)) dut (
        .clk(clk), .por_req_i(por_req), .bod_req_i(bod_req),
        .rwdt_req_i(rwdt_req), .swsys_req_i(sw_req), .mwdt_req_i(mwdt_req),
        .sleep_req_i(sleep_req), .cpu_req_i(cpu_req), .cause_sel_i(sel),
        .rtc_rst_o(rtc_rst), .dig_rst_o(dig_rst), .cpu_rst_o(cpu_rst),
        .cause_o(cause));

    typedef struct {
        int          core;
        logic [7:0]  code;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   pushed = 0;
    int   done   = 0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic expect_cause(input int core, input logic [7:0] code, input string tag);
        exp_t e;
        e.core = core; e.code = code; e.tag = tag;
        exp_q.push_back(e);
        pushed++;
    endtask

    // monitor: pops expected items and compares the read port
    initial begin
        forever begin
            exp_t e;
            wait (exp_q.size() != 0);
            @(negedge clk);
            e = exp_q.pop_front();
            sel = 1'(e.core);
            #1;
            check(cause == e.code, e.tag, cause, e.code);
            done++;
        end
    end

    task automatic drain;
        wait (done == pushed);
    endtask

    // mask bits: 0 por,1 bod,2 rwdt,3 sw,4 mwdt,5 sleep,6.. cpu
    task automatic drive(input logic [5+NCORE:0] m);
        por_req   = m[0];
        bod_req   = m[1];
        rwdt_req  = m[2];
        sw_req    = m[3];
        mwdt_req  = m[4];
        sleep_req = m[5];
        cpu_req   = m[6 +: NCORE];
    endtask

    task automatic apply(input logic [5+NCORE:0] m, input int e_rtc, input int e_dig,
                         input int e_c0, input int e_c1, input string tag);
        int n_rtc = 0, n_dig = 0, n_c0 = 0, n_c1 = 0;
        @(negedge clk);
        drive(m);
        #1;
        // R1: immediate assertion before any clock edge
        if (e_rtc > 0)      check(rtc_rst == 1'b1, {"R1 rtc ", tag}, rtc_rst, 1);
        else if (e_dig > 0) check(dig_rst == 1'b1, {"R1 dig ", tag}, dig_rst, 1);
        else                check(cpu_rst == (e_c0 > 0 ? 2'b01 : 2'b10),
                                  {"R1 cpu ", tag}, cpu_rst, e_c0 > 0 ? 1 : 2);
        repeat (6) @(negedge clk);
        drive('0);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (rtc_rst)    n_rtc++;
            if (dig_rst)    n_dig++;
            if (cpu_rst[0]) n_c0++;
            if (cpu_rst[1]) n_c1++;
            if (!rtc_rst && !dig_rst && cpu_rst == '0) break;
        end
        check(n_rtc == e_rtc, {"R2/R4 rtc release ", tag}, n_rtc, e_rtc);
        check(n_dig == e_dig, {"R3 dig release ", tag}, n_dig, e_dig);
        check(n_c0 == e_c0,   {"R3/R7 cpu0 release ", tag}, n_c0, e_c0);
        check(n_c1 == e_c1,   {"R3/R7 cpu1 release ", tag}, n_c1, e_c1);
        repeat (3) @(negedge clk);
    endtask

    localparam logic [7:0] M_POR = 8'h01, M_BOD = 8'h02, M_RWDT = 8'h04, M_SW = 8'h08,
                           M_MWDT = 8'h10, M_SLP = 8'h20, M_C0 = 8'h40, M_C1 = 8'h80;

    initial begin
        #1 por_req = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        check(rtc_rst && dig_rst && cpu_rst == 2'b11, "R5 reset state outputs",
              {rtc_rst, dig_rst, cpu_rst}, 4'hF);
        expect_cause(0, 8'h01, "R5 por hold core0");
        expect_cause(1, 8'h01, "R5 por hold core1");
        drain();
        apply(M_POR, 18, 35, 52, 52, "R5 por");
        expect_cause(0, 8'h01, "R5 por core0"); expect_cause(1, 8'h01, "R5 por core1"); drain();

        apply(M_BOD, 18, 35, 52, 52, "R5 bod");
        expect_cause(0, 8'h0F, "R5 bod core0"); expect_cause(1, 8'h0F, "R5 bod core1"); drain();
        apply(M_RWDT, 18, 35, 52, 52, "R5 rwdt");
        expect_cause(0, 8'h10, "R5 rwdt core0"); expect_cause(1, 8'h10, "R5 rwdt core1"); drain();

        apply(M_SW, 0, 18, 35, 35, "R4 R6 sw");
        expect_cause(0, 8'h03, "R6 sw core0"); expect_cause(1, 8'h03, "R6 sw core1"); drain();
        apply(M_MWDT, 0, 18, 35, 35, "R4 R6 mwdt");
        expect_cause(0, 8'h07, "R6 mwdt core0"); expect_cause(1, 8'h07, "R6 mwdt core1"); drain();
        apply(M_SLP, 0, 18, 35, 35, "R4 R6 sleep");
        expect_cause(0, 8'h05, "R6 sleep core0"); expect_cause(1, 8'h05, "R6 sleep core1"); drain();

        apply(M_C0, 0, 0, 18, 0, "R7 cpu0");
        expect_cause(0, 8'h0C, "R7 cpu0 code"); expect_cause(1, 8'h05, "R9 core1 kept"); drain();
        apply(M_C1, 0, 0, 0, 18, "R7 cpu1");
        expect_cause(0, 8'h0C, "R9 core0 kept"); expect_cause(1, 8'h0C, "R7 cpu1 code"); drain();

        apply(M_SW | M_MWDT | M_SLP, 0, 18, 35, 35, "R8 sw+mwdt+sleep");
        expect_cause(0, 8'h03, "R8 sw wins c0"); expect_cause(1, 8'h03, "R8 sw wins c1"); drain();
        apply(M_MWDT | M_SLP, 0, 18, 35, 35, "R8 mwdt+sleep");
        expect_cause(0, 8'h07, "R8 mwdt wins c0"); expect_cause(1, 8'h07, "R8 mwdt wins c1"); drain();
        apply(M_RWDT | M_SW | M_C0, 18, 35, 52, 52, "R8 rwdt+sw+cpu0");
        expect_cause(0, 8'h10, "R8 rwdt wins c0"); expect_cause(1, 8'h10, "R8 rwdt wins c1"); drain();
        apply(M_BOD | M_RWDT, 18, 35, 52, 52, "R8 bod+rwdt");
        expect_cause(0, 8'h0F, "R8 bod wins c0"); expect_cause(1, 8'h0F, "R8 bod wins c1"); drain();
        apply(M_SLP | M_C1, 0, 18, 35, 35, "R8 sleep+cpu1");
        expect_cause(0, 8'h05, "R8 sleep wins c0"); expect_cause(1, 8'h05, "R8 sleep wins c1"); drain();

        apply(M_MWDT, 0, 18, 35, 35, "R9 mwdt");
        apply(M_C1, 0, 0, 0, 18, "R9 cpu1 after mwdt");
        expect_cause(0, 8'h07, "R9 core0 retained"); expect_cause(1, 8'h0C, "R9 core1 cpu"); drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired R1 actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule